// File: doc/BRIEF.md
# Configuration Image Header Scanner

This block sits between a byte source that delivers a whole configuration image file and a loader that only wants the raw configuration data. Bytes arrive on a valid/ready stream with a flag on the final byte of each image. The block walks a chain of length-prefixed text fields near the start of the file and hunts for a synchronisation preamble. It discards everything ahead of the payload. From the payload start onward, it forwards bytes downstream on a second valid/ready stream, and the final forwarded byte carries the last flag.

Two preamble styles exist, chosen per image by a mode input. In the four-byte style, the search begins where the fourth header field ends. The payload starts with a run of four 0xFF bytes, and those four bytes are part of what is forwarded. In the nibble style, the search starts at the first byte of the file and ignores the header walk. The preamble is a 0xFF byte followed by a byte whose upper nibble is 3, and the payload begins after that pair. If an image ends before any preamble is found, an error flag is raised. A counter reports how many payload bytes the current image has produced.

Top module: `cfg_hdr_scan`

## Requirements
- R1: After reset, m_valid is 0, s_ready is 1, no_sync is 0 and pay_count is 0.
- R2: With sync_mode = 1, the header walk begins at byte offset 15 of the image. The byte at a field start gives a length L, and the next field starts L+3 bytes later. Exactly four fields are walked. A run of 0xFF bytes that ends before the end of the fourth field does not start the payload.
- R3: With sync_mode = 1, the payload begins at the first of four consecutive 0xFF bytes at or after the end of the fourth field. Those four bytes and every later byte of the image are forwarded in order.
- R4: With sync_mode = 0, the preamble is a 0xFF byte followed by a byte whose bits [7:4] equal 4'h3. The search covers the image from byte 0, header region included. The pair itself is not forwarded, and every byte after it is forwarded in order.
- R5: A 0xFF byte re-arms the match instead of breaking it. In nibble mode, FF FF 3x matches on the second 0xFF. In four-byte mode, a run broken by a non-0xFF byte restarts the count, and a later run of four or more matches at its first byte.
- R6: m_last is 1 on the final forwarded byte of an image and on no other byte. This includes the case where the image ends on the fourth preamble 0xFF.
- R7: If an image ends with no preamble found, no_sync goes to 1 and no byte is forwarded. no_sync stays 1 until the first byte of the next image is accepted.
- R8: pay_count equals the number of payload bytes forwarded for the current image. It returns to 0 when the first byte of the next image is accepted.
- R9: While m_ready is 0, no payload byte is lost or repeated, and a pending preamble byte stays on m_data as 0xFF with m_valid held at 1.
- R10: In nibble mode, a preamble pair that ends the image produces no output and leaves no_sync at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1 = four 0xFF preamble after header walk, 0 = 0xFF plus nibble-3 pair; held for a whole image |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input image byte |
| s_last | input | 1 | Marks the final byte of an image |
| s_ready | output | 1 | Block accepts the input byte |
| m_valid | output | 1 | Payload byte valid |
| m_data | output | 8 | Payload byte |
| m_last | output | 1 | Marks the final payload byte |
| m_ready | input | 1 | Downstream accepts the payload byte |
| pay_count | output | CNT_W | Payload bytes forwarded for the current image |
| no_sync | output | 1 | Image ended without a preamble |

## Verification
The images vary the header field lengths, including all-zero and long fields, and the gap before the preamble. This shows whether the walk lands at the offset the L+3 rule predicts. Decoy preambles are placed inside the first fifteen bytes. In four-byte mode they must be skipped, and in nibble mode they must win, which separates the two search origins. Near-miss runs (three 0xFF bytes then a break, FF FF 3x) and images that end on the preamble itself probe the re-arming and last-flag corners. Periodic stalls on both sides check that nothing is dropped or duplicated under backpressure.

// File: rtl/cfg_hdr_scan_pkg.sv
package cfg_hdr_scan_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t SYNC_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PH_SCAN  = 2'd0,
        PH_BURST = 2'd1,
        PH_PASS  = 2'd2
    } phase_e;

    function automatic logic is_sync(input byte_t b);
        return b == SYNC_BYTE;
    endfunction

    function automatic logic nib_hit(input byte_t b, input logic [3:0] n);
        return b[7:4] == n;
    endfunction

endpackage

// File: rtl/cfg_hdr_walk.sv
module cfg_hdr_walk
    import cfg_hdr_scan_pkg::*;
#(
    parameter int POS_W      = 16,
    parameter int HDR_START  = 15,
    parameter int HDR_FIELDS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             acc_i,
    input  byte_t            byte_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             search_on_o
);
    localparam int FLD_W = $clog2(HDR_FIELDS + 1);

    logic [POS_W-1:0] nxt_q;
    logic [FLD_W-1:0] nfld_q;
    logic             walking;

    assign walking     = nfld_q < FLD_W'(HDR_FIELDS);
    assign search_on_o = !walking && (pos_i >= nxt_q);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            nxt_q  <= POS_W'(HDR_START);
            nfld_q <= '0;
        end else if (acc_i && walking && (pos_i == nxt_q)) begin
            nxt_q  <= pos_i + POS_W'(byte_i) + POS_W'(3);
            nfld_q <= nfld_q + 1'b1;
        end
    end

    // R2
    fld_bound_chk: assert property (@(posedge clk) disable iff (rst)
        nfld_q <= FLD_W'(HDR_FIELDS));

endmodule

// File: rtl/cfg_sync_det.sv
module cfg_sync_det
    import cfg_hdr_scan_pkg::*;
#(
    parameter int         SYNC_RUN = 4,
    parameter logic [3:0] SYNC_NIB = 4'h3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  acc_i,
    input  byte_t byte_i,
    input  logic  mode_i,
    input  logic  search_on_i,
    output logic  hit_o
);
    localparam int RUN_W = (SYNC_RUN > 2) ? $clog2(SYNC_RUN) : 1;
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(SYNC_RUN - 1);

    logic [RUN_W-1:0] run_q;
    logic             prev_ff_q;
    logic             run_hit, pair_hit, ff_now;

    assign ff_now   = is_sync(byte_i);
    assign run_hit  = mode_i && search_on_i && ff_now && (run_q == RUN_TOP);
    assign pair_hit = !mode_i && prev_ff_q && nib_hit(byte_i, SYNC_NIB);
    assign hit_o    = run_hit || pair_hit;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            run_q     <= '0;
            prev_ff_q <= 1'b0;
        end else if (acc_i) begin
            prev_ff_q <= ff_now;
            if (mode_i && search_on_i && ff_now)
                run_q <= (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
            else
                run_q <= '0;
        end
    end

endmodule

// File: rtl/cfg_pay_gate.sv
module cfg_pay_gate
    import cfg_hdr_scan_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_i,
    input  logic             hit_i,
    input  logic             first_i,
    input  logic             in_valid_i,
    input  byte_t            in_data_i,
    input  logic             in_last_i,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output byte_t            out_data_o,
    output logic             out_last_o,
    input  logic             out_ready_i,
    output logic             acc_o,
    output logic             end_o,
    output logic [CNT_W-1:0] count_o,
    output logic             err_o
);
    localparam int RUN_W = (SYNC_RUN > 2) ? $clog2(SYNC_RUN) : 1;

    phase_e           phase_q;
    logic [RUN_W-1:0] left_q;
    logic             last_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             out_hs;

    always_comb begin
        in_ready_o  = 1'b1;
        out_valid_o = 1'b0;
        out_data_o  = in_data_i;
        out_last_o  = 1'b0;
        unique case (phase_q)
            PH_BURST: begin
                in_ready_o  = 1'b0;
                out_valid_o = 1'b1;
                out_data_o  = SYNC_BYTE;
                out_last_o  = last_q && (left_q == '0);
            end
            PH_PASS: begin
                in_ready_o  = out_ready_i;
                out_valid_o = in_valid_i;
                out_last_o  = in_last_i;
            end
            default: ;
        endcase
    end

    assign out_hs  = out_valid_o && out_ready_i;
    assign acc_o   = in_valid_i && in_ready_o;
    assign end_o   = ((phase_q == PH_SCAN) && in_valid_i && in_last_i && !(hit_i && mode_i))
                   || (out_hs && out_last_o);
    assign count_o = cnt_q;
    assign err_o   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_SCAN;
            left_q  <= '0;
            last_q  <= 1'b0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_SCAN: if (in_valid_i) begin
                    if (first_i) begin
                        cnt_q <= '0;
                        err_q <= 1'b0;
                    end
                    if (hit_i) begin
                        if (mode_i) begin
                            phase_q <= PH_BURST;
                            left_q  <= RUN_W'(SYNC_RUN - 1);
                            last_q  <= in_last_i;
                        end else if (!in_last_i) begin
                            phase_q <= PH_PASS;
                        end
                    end else if (in_last_i) begin
                        err_q <= 1'b1;
                    end
                end
                PH_BURST: if (out_ready_i) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (left_q == '0)
                        phase_q <= last_q ? PH_SCAN : PH_PASS;
                    else
                        left_q <= left_q - 1'b1;
                end
                PH_PASS: if (out_hs) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (in_last_i)
                        phase_q <= PH_SCAN;
                end
                default: phase_q <= PH_SCAN;
            endcase
        end
    end

    // R6
    last_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && out_ready_i && out_last_o) |=> (phase_q == PH_SCAN));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(in_valid_i && in_ready_o && in_last_i));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0));

    // R9
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BURST && !out_ready_i) |=> (out_valid_o && out_data_o == SYNC_BYTE));

endmodule

// File: rtl/cfg_hdr_scan.sv
module cfg_hdr_scan
    import cfg_hdr_scan_pkg::*;
#(
    parameter int         POS_W      = 16,
    parameter int         CNT_W      = 16,
    parameter int         HDR_START  = 15,
    parameter int         HDR_FIELDS = 4,
    parameter int         SYNC_RUN   = 4,
    parameter logic [3:0] SYNC_NIB   = 4'h3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_mode,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic             m_valid,
    output logic [7:0]       m_data,
    output logic             m_last,
    input  logic             m_ready,
    output logic [CNT_W-1:0] pay_count,
    output logic             no_sync
);
    logic [POS_W-1:0] pos_q;
    logic             acc, img_end, search_on, hit;

    always_ff @(posedge clk) begin
        if (rst || img_end)
            pos_q <= '0;
        else if (acc)
            pos_q <= pos_q + 1'b1;
    end

    cfg_hdr_walk #(
        .POS_W(POS_W), .HDR_START(HDR_START), .HDR_FIELDS(HDR_FIELDS)
    ) u_walk (
        .clk(clk), .rst(rst), .clr_i(img_end), .acc_i(acc),
        .byte_i(s_data), .pos_i(pos_q), .search_on_o(search_on)
    );

    cfg_sync_det #(
        .SYNC_RUN(SYNC_RUN), .SYNC_NIB(SYNC_NIB)
    ) u_det (
        .clk(clk), .rst(rst), .clr_i(img_end), .acc_i(acc),
        .byte_i(s_data), .mode_i(sync_mode), .search_on_i(search_on), .hit_o(hit)
    );

    cfg_pay_gate #(
        .CNT_W(CNT_W), .SYNC_RUN(SYNC_RUN)
    ) u_gate (
        .clk(clk), .rst(rst), .mode_i(sync_mode), .hit_i(hit),
        .first_i(pos_q == '0),
        .in_valid_i(s_valid), .in_data_i(s_data), .in_last_i(s_last), .in_ready_o(s_ready),
        .out_valid_o(m_valid), .out_data_o(m_data), .out_last_o(m_last), .out_ready_i(m_ready),
        .acc_o(acc), .end_o(img_end), .count_o(pay_count), .err_o(no_sync)
    );

endmodule

// File: tb/cfg_hdr_scan_test.sv
module cfg_hdr_scan_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_mode = 1'b0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = 8'h00;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        m_valid;
    logic [7:0]  m_data;
    logic        m_last;
    logic        m_ready = 1'b1;
    logic [15:0] pay_count;
    logic        no_sync;

    int errors = 0;
    int checks = 0;

    logic [7:0] img [0:255];
    logic [7:0] got [0:255];
    int n;

    typedef struct packed {
        logic       md;
        logic       decoy;
        logic       stall;
        logic [7:0] l0;
        logic [7:0] l1;
        logic [7:0] l2;
        logic [7:0] l3;
        logic [7:0] gap;
        logic [7:0] plen;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 8'd3,  8'd0,  8'd5,  8'd1,  8'd2, 8'd10},
        '{1'b1, 1'b1, 1'b1, 8'd10, 8'd2,  8'd0,  8'd7,  8'd0, 8'd20},
        '{1'b0, 1'b0, 1'b0, 8'd4,  8'd4,  8'd4,  8'd4,  8'd3, 8'd12},
        '{1'b0, 1'b1, 1'b1, 8'd6,  8'd1,  8'd2,  8'd3,  8'd1, 8'd8},
        '{1'b1, 1'b0, 1'b1, 8'd40, 8'd30, 8'd20, 8'd10, 8'd5, 8'd33},
        '{1'b0, 1'b0, 1'b1, 8'd0,  8'd0,  8'd0,  8'd0,  8'd0, 8'd1}
    };

    always #5 clk = ~clk;

    cfg_hdr_scan uut (
        .clk(clk), .rst(rst), .sync_mode(sync_mode),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready),
        .pay_count(pay_count), .no_sync(no_sync)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        img[n] = b;
        n++;
    endtask

    task automatic build_hdr(input int l0, input int l1, input int l2, input int l3,
                             input bit decoy, input bit md);
        int lens [4];
        lens = '{l0, l1, l2, l3};
        n = 0;
        for (int i = 0; i < 15; i++) push(8'h11);
        if (decoy) begin
            if (md) begin
                img[5] = 8'hFF; img[6] = 8'hFF; img[7] = 8'hFF; img[8] = 8'hFF;
            end else begin
                img[5] = 8'hFF; img[6] = 8'h3A;
            end
        end
        for (int f = 0; f < 4; f++) begin
            push(8'(lens[f]));
            for (int j = 0; j < lens[f] + 2; j++) push(8'h22);
        end
    endtask

    // Independent model: payload start index, or -1 when there is no preamble.
    function automatic int ref_start(input bit md);
        int idx;
        if (md) begin
            idx = 15;
            for (int f = 0; f < 4; f++) idx += int'(img[idx]) + 3;
            for (int k = idx; k + 3 < n; k++)
                if (img[k] == 8'hFF && img[k+1] == 8'hFF && img[k+2] == 8'hFF && img[k+3] == 8'hFF)
                    return k;
            return -1;
        end
        for (int k = 0; k + 1 < n; k++)
            if (img[k] == 8'hFF && img[k+1][7:4] == 4'h3) return k + 2;
        return -1;
    endfunction

    task automatic run_image(input bit md, input bit stall, input string tag);
        int si = 0, cyc = 0, quiet = 0, gotn = 0, lasts = 0, lastpos = -1;
        int st, elen, mism;
        sync_mode = md;
        while (quiet < 12 && cyc < 3000) begin
            @(negedge clk);
            s_valid = (si < n) && (!stall || (cyc % 5) != 2);
            s_data  = (si < n) ? img[si] : 8'h00;
            s_last  = (si == n - 1);
            m_ready = !stall || (cyc % 3) != 0;
            #1;
            if (s_valid && s_ready) si++;
            if (m_valid && m_ready) begin
                got[gotn] = m_data;
                if (m_last) begin lasts++; lastpos = gotn; end
                gotn++;
            end
            if (si >= n && !m_valid) quiet++;
            cyc++;
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
        m_ready = 1'b1;
        #1;
        check(tag, "image completes", int'(cyc < 3000), 1);
        st   = ref_start(md);
        elen = (st < 0) ? 0 : n - st;
        check(tag, "payload length", gotn, elen);
        mism = 0;
        for (int k = 0; k < gotn && k < elen; k++)
            if (got[k] != img[st + k]) mism++;
        check(tag, "payload byte mismatches", mism, 0);
        check({tag, ",R6"}, "last flag count", lasts, (elen > 0) ? 1 : 0);
        if (elen > 0) check({tag, ",R6"}, "last flag position", lastpos, elen - 1);
        check({tag, ",R8"}, "pay_count", int'(pay_count), elen);
        check({tag, ",R7"}, "no_sync", int'(no_sync), int'(st < 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        check("R1", "m_valid", int'(m_valid), 0);
        check("R1", "s_ready", int'(s_ready), 1);
        check("R1", "no_sync", int'(no_sync), 0);
        check("R1", "pay_count", int'(pay_count), 0);

        // Table of images: R2 walk, R3 four-byte mode, R4 nibble mode, R9 stalls
        for (int v = 0; v < NV; v++) begin
            build_hdr(int'(VEC[v].l0), int'(VEC[v].l1), int'(VEC[v].l2), int'(VEC[v].l3),
                      VEC[v].decoy, VEC[v].md);
            for (int g = 0; g < int'(VEC[v].gap); g++) push(8'h5A);
            if (VEC[v].md) begin
                push(8'hFF); push(8'hFF); push(8'hFF); push(8'hFF);
            end else begin
                push(8'hFF); push(8'h3C);
            end
            for (int k = 0; k < int'(VEC[v].plen); k++) push(8'((k * 37 + 5) & 255));
            run_image(VEC[v].md, VEC[v].stall, VEC[v].md ? "R2,R3,R9" : "R4,R9");
        end

        // R7: no preamble, near-miss run after the header
        build_hdr(2, 3, 1, 0, 1'b0, 1'b1);
        push(8'hFF); push(8'hFF); push(8'hFF); push(8'h00); push(8'h44);
        run_image(1'b1, 1'b0, "R7");

        // R7, R8: next image clears the error and restarts the count
        n = 0;
        push(8'hFF); push(8'h31); push(8'hAA); push(8'hBB);
        run_image(1'b0, 1'b0, "R7,R8");

        // R5: FF FF 3x in nibble mode matches on the second FF
        n = 0;
        push(8'h00); push(8'hFF); push(8'hFF); push(8'h35); push(8'h01); push(8'h02);
        run_image(1'b0, 1'b1, "R5");

        // R5: broken run then a run of five in four-byte mode
        build_hdr(1, 1, 1, 1, 1'b0, 1'b1);
        push(8'hFF); push(8'hFF); push(8'hFF); push(8'h00);
        push(8'hFF); push(8'hFF); push(8'hFF); push(8'hFF); push(8'hFF); push(8'h09);
        run_image(1'b1, 1'b0, "R5");

        // R6, R9: image ends on the fourth preamble byte, under stalls
        build_hdr(0, 2, 0, 2, 1'b0, 1'b1);
        push(8'h5A); push(8'hFF); push(8'hFF); push(8'hFF); push(8'hFF);
        run_image(1'b1, 1'b1, "R6,R9");

        // R10: nibble-mode pair at the very end
        n = 0;
        push(8'h10); push(8'h20); push(8'hFF); push(8'h3F);
        run_image(1'b0, 1'b0, "R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule